// File: doc/BRIEF.md
# Optical Black Clamp

This block sits at the head of a raw sensor pixel pipeline. It receives a stream of 10-bit samples with a pixel-valid strobe, horizontal and vertical reference strobes and a field identifier. It then removes the sensor's dark offset from every sample before any colour work is done. A fixed 16 x 128 measurement window can be placed anywhere in the frame, with a separate origin for each field. The block sums the samples inside the window into four buckets, one for each combination of field and column parity. Each bucket is divided down to an average black level.

With the clamp enabled, each sample has the measured average of its own bucket subtracted. With the clamp disabled, it has one of eight programmable signed offsets subtracted, chosen by field, line parity and column parity. The result saturates to the 10-bit code range. The four measured levels are brought out continuously so that a control processor can read them.

Top module: `ob_clamp`

## Requirements
- R1: Synchronous reset drives `out_vld`, `out_pix` and all of `black_lvl` to zero and discards every stored average.
- R2: Column x is the number of valid pixels seen since the last rising edge of `hs`, so the first valid pixel of a line is x=0. Line y counts rising edges of `hs` after a rising edge of `vs`, and the first line after `vs` rises is y=0.
- R3: The window covers columns wx..wx+15 and lines wy..wy+127. (wx, wy) is taken from `win_x_odd`/`win_y_odd` when `fld`=1 and from `win_x_even`/`win_y_even` when `fld`=0.
- R4: Bucket index b = {fld, x[0]}. Each bucket's level is the floor of the sum of its 1024 window samples divided by 1024. It is updated right after the last window pixel of a frame of its field, and it appears on `black_lvl[b*10 +: 10]`.
- R5: A level is used for subtraction only from the next rising edge of `vs`. The pixels of the frame in which it was measured still use the level that was in force when that frame began.
- R6: With `clamp_en`=1, a pixel's output is pix minus the applied level of bucket {fld, x[0]}, floored at 0.
- R7: With `clamp_en`=0, a pixel's output is pix minus the signed 11-bit offset `fix_ofs[k*11 +: 11]`, where k = {fld, y[0], x[0]}. The result saturates at 0 and at 1023.
- R8: `out_vld` follows `pix_vld` one clock later. A valid output carries the result for the pixel of the previous clock, and `out_pix` holds its value while `out_vld` is low.
- R9: Black-level measurement and level updates run regardless of `clamp_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_vld | input | 1 | Input sample valid |
| pix_in | input | 10 | Raw sensor sample |
| hs | input | 1 | Horizontal reference strobe |
| vs | input | 1 | Vertical reference strobe |
| fld | input | 1 | Field identifier (1 = odd) |
| clamp_en | input | 1 | 1: subtract measured black, 0: subtract fixed offset |
| win_x_even | input | 10 | Window column origin, even field |
| win_y_even | input | 11 | Window line origin, even field |
| win_x_odd | input | 10 | Window column origin, odd field |
| win_y_odd | input | 11 | Window line origin, odd field |
| fix_ofs | input | 88 | Eight signed 11-bit fixed offsets |
| out_vld | output | 1 | Output sample valid |
| out_pix | output | 10 | Corrected sample |
| black_lvl | output | 40 | Four measured black levels, bucket b at bits b*10+9..b*10 |

## Verification
Corrected pixels are due one clock after they are presented. The bench drives on falling edges and compares each output on the following falling edge against a value it computed when it drove that pixel. The black levels change at the last window pixel but take effect on pixels only after the next `vs` rise. The bench model therefore updates its own levels at frame end and applies them when it starts the next frame. The `black_lvl` port is compared once a frame has finished and two idle clocks have passed.

// File: rtl/ob_pkg.sv
package ob_pkg;
  localparam int NBUCKET = 4;
  localparam int NFIX    = 8;
  typedef logic [1:0] bucket_t;
  typedef logic [2:0] fix_idx_t;
endpackage

// File: rtl/ob_timing.sv
module ob_timing #(
  parameter int HCNT_W = 10,
  parameter int VCNT_W = 11,
  parameter int WIN_W  = 16,
  parameter int WIN_H  = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_vld,
  input  logic              hs,
  input  logic              vs,
  input  logic              fld,
  input  logic [HCNT_W-1:0] wx_even,
  input  logic [VCNT_W-1:0] wy_even,
  input  logic [HCNT_W-1:0] wx_odd,
  input  logic [VCNT_W-1:0] wy_odd,
  output logic              vs_rise,
  output logic              x_odd,
  output logic              y_odd,
  output logic              in_win,
  output logic              win_end
);
  localparam logic [HCNT_W-1:0] WW = HCNT_W'(WIN_W);
  localparam logic [VCNT_W-1:0] WH = VCNT_W'(WIN_H);

  logic hs_q, vs_q, hs_rise;
  logic [HCNT_W-1:0] hcnt, wx, dx;
  logic [VCNT_W-1:0] vcnt, wy, dy, vbase;
  logic in_x, in_y;

  assign hs_rise = hs & ~hs_q;
  assign vs_rise = vs & ~vs_q;
  assign vbase   = vs_rise ? '1 : vcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      hcnt <= '0;
      vcnt <= '1;
    end else begin
      hs_q <= hs;
      vs_q <= vs;
      vcnt <= vbase + VCNT_W'(hs_rise);
      if (hs_rise)                      hcnt <= '0;
      else if (pix_vld && hcnt != '1)   hcnt <= hcnt + 1'b1;
    end
  end

  always_comb begin
    wx      = fld ? wx_odd : wx_even;
    wy      = fld ? wy_odd : wy_even;
    dx      = hcnt - wx;
    dy      = vcnt - wy;
    in_x    = (hcnt >= wx) && (dx < WW);
    in_y    = (vcnt >= wy) && (dy < WH);
    in_win  = pix_vld && in_x && in_y;
    win_end = in_win && (dx == WW - 1'b1) && (dy == WH - 1'b1);
    x_odd   = hcnt[0];
    y_odd   = vcnt[0];
  end
endmodule

// File: rtl/ob_accum.sv
module ob_accum #(
  parameter int PIX_W = 10,
  parameter int SUM_W = 20,
  parameter int SHIFT = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             last,
  input  logic [PIX_W-1:0] pix,
  output logic [PIX_W-1:0] avg
);
  logic [SUM_W-1:0] acc, sum_nxt;

  assign sum_nxt = acc + (hit ? SUM_W'(pix) : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      avg <= '0;
    end else if (last) begin
      avg <= PIX_W'(sum_nxt >> SHIFT);
      acc <= '0;
    end else begin
      acc <= sum_nxt;
    end
  end

  AST_AVG_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
    !last |=> $stable(avg)); // R4
endmodule

// File: rtl/ob_sub.sv
module ob_sub #(
  parameter int PIX_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pix_vld,
  input  logic [PIX_W-1:0]        pix_in,
  input  logic                    clamp_en,
  input  logic [PIX_W-1:0]        avg_sel,
  input  logic signed [PIX_W:0]   fix_sel,
  output logic                    out_vld,
  output logic [PIX_W-1:0]        out_pix
);
  localparam int DW = PIX_W + 2;
  localparam logic signed [DW-1:0] MAXV = DW'((1 << PIX_W) - 1);

  logic signed [DW-1:0] sub_v, diff;
  logic [PIX_W-1:0] sat;

  always_comb begin
    sub_v = clamp_en ? $signed({2'b00, avg_sel}) : $signed({fix_sel[PIX_W], fix_sel});
    diff  = $signed({2'b00, pix_in}) - sub_v;
    if (diff < 0)          sat = '0;
    else if (diff > MAXV)  sat = '1;
    else                   sat = diff[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_pix <= '0;
    end else begin
      out_vld <= pix_vld;
      if (pix_vld) out_pix <= sat;
    end
  end

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    pix_vld |=> out_vld); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pix_vld |=> (!out_vld && $stable(out_pix))); // R8
  AST_CLAMP_NO_RAISE: assert property (@(posedge clk) disable iff (rst)
    (clamp_en && pix_vld) |=> (out_pix <= $past(pix_in))); // R6
  AST_ZERO_OFS_PASS: assert property (@(posedge clk) disable iff (rst)
    (!clamp_en && pix_vld && fix_sel == 0) |=> (out_pix == $past(pix_in))); // R7
endmodule

// File: rtl/ob_clamp.sv
module ob_clamp #(
  parameter int PIX_W  = 10,
  parameter int HCNT_W = 10,
  parameter int VCNT_W = 11,
  parameter int WIN_W  = 16,
  parameter int WIN_H  = 128
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         pix_vld,
  input  logic [PIX_W-1:0]             pix_in,
  input  logic                         hs,
  input  logic                         vs,
  input  logic                         fld,
  input  logic                         clamp_en,
  input  logic [HCNT_W-1:0]            win_x_even,
  input  logic [VCNT_W-1:0]            win_y_even,
  input  logic [HCNT_W-1:0]            win_x_odd,
  input  logic [VCNT_W-1:0]            win_y_odd,
  input  logic [8*(PIX_W+1)-1:0]       fix_ofs,
  output logic                         out_vld,
  output logic [PIX_W-1:0]             out_pix,
  output logic [4*PIX_W-1:0]           black_lvl
);
  import ob_pkg::*;

  localparam int OW    = PIX_W + 1;
  localparam int SHIFT = $clog2(WIN_W * WIN_H / 2);
  localparam int SUM_W = PIX_W + SHIFT;

  logic vs_rise, x_odd, y_odd, in_win, win_end;
  bucket_t  bkt;
  fix_idx_t fidx;
  logic [NBUCKET-1:0][PIX_W-1:0] avg, applied;
  logic signed [OW-1:0] fix_arr [NFIX];

  ob_timing #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W), .WIN_W(WIN_W), .WIN_H(WIN_H)) u_timing (
    .clk(clk), .rst(rst), .pix_vld(pix_vld), .hs(hs), .vs(vs), .fld(fld),
    .wx_even(win_x_even), .wy_even(win_y_even), .wx_odd(win_x_odd), .wy_odd(win_y_odd),
    .vs_rise(vs_rise), .x_odd(x_odd), .y_odd(y_odd), .in_win(in_win), .win_end(win_end)
  );

  assign bkt  = {fld, x_odd};
  assign fidx = {fld, y_odd, x_odd};

  for (genvar b = 0; b < NBUCKET; b++) begin : g_bucket
    ob_accum #(.PIX_W(PIX_W), .SUM_W(SUM_W), .SHIFT(SHIFT)) u_acc (
      .clk(clk), .rst(rst),
      .hit(in_win && bkt == bucket_t'(b)),
      .last(win_end && fld == b[1]),
      .pix(pix_in),
      .avg(avg[b])
    );
  end

  for (genvar k = 0; k < NFIX; k++) begin : g_fix
    assign fix_arr[k] = fix_ofs[k*OW +: OW];
  end

  always_ff @(posedge clk) begin
    if (rst)          applied <= '0;
    else if (vs_rise) applied <= avg;
  end

  assign black_lvl = avg;

  ob_sub #(.PIX_W(PIX_W)) u_sub (
    .clk(clk), .rst(rst), .pix_vld(pix_vld), .pix_in(pix_in),
    .clamp_en(clamp_en), .avg_sel(applied[bkt]), .fix_sel(fix_arr[fidx]),
    .out_vld(out_vld), .out_pix(out_pix)
  );

  AST_APPLY_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
    !vs_rise |=> $stable(applied)); // R5
endmodule

// File: tb/tb_ob_clamp.sv
module tb_ob_clamp;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_vld = 1'b0, hs = 1'b0, vs = 1'b0, fld = 1'b0, clamp_en = 1'b0;
  logic [9:0] pix_in = '0;
  logic [9:0] win_x_even = 10'd4, win_x_odd = 10'd7;
  logic [10:0] win_y_even = 11'd2, win_y_odd = 11'd5;
  logic [87:0] fix_ofs;
  logic out_vld;
  logic [9:0] out_pix;
  logic [39:0] black_lvl;

  always #2.5 clk = ~clk;

  ob_clamp dut (
    .clk(clk), .rst(rst), .pix_vld(pix_vld), .pix_in(pix_in), .hs(hs), .vs(vs), .fld(fld),
    .clamp_en(clamp_en), .win_x_even(win_x_even), .win_y_even(win_y_even),
    .win_x_odd(win_x_odd), .win_y_odd(win_y_odd), .fix_ofs(fix_ofs),
    .out_vld(out_vld), .out_pix(out_pix), .black_lvl(black_lvl)
  );

  int checks = 0, failures = 0;
  int fixv [8] = '{-20, 5, 30, 900, -300, 0, 64, 1000};
  int base [4] = '{40, 61, 33, 77};
  int meas [4], appl [4];
  logic prev_v = 1'b0;
  logic [9:0] prev_e = '0, last_e = '0;
  int bad_pix, bad_lat, first_act, first_exp;

  // vector: {clamp_en, fld, lvl[7:0]}
  localparam int NVEC = 6;
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'd0}, {1'b0, 1'b1, 8'd0}, {1'b1, 1'b0, 8'd10},
    {1'b1, 1'b1, 8'd20}, {1'b1, 1'b0, 8'd5}, {1'b1, 1'b1, 8'd0}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [9:0] p, input logic h, input logic s,
                      input logic [9:0] e);
    @(negedge clk);
    if (out_vld !== prev_v) bad_lat++;
    if (prev_v) begin
      if (out_pix !== prev_e) begin
        if (bad_pix == 0) begin first_act = int'(out_pix); first_exp = int'(prev_e); end
        bad_pix++;
      end
      last_e = prev_e;
    end else if (out_pix !== last_e) bad_lat++;
    pix_vld = v; pix_in = p; hs = h; vs = s;
    prev_v = v; prev_e = e;
  endtask

  task automatic run_frame(input logic en, input logic f, input int lvl);
    int sum [2];
    int wx, wy, p, d, b, off;
    bit inw;
    clamp_en = en; fld = f;
    sum[0] = 0; sum[1] = 0;
    bad_pix = 0; bad_lat = 0; first_act = 0; first_exp = 0;
    for (int i = 0; i < 4; i++) appl[i] = meas[i];
    wx = f ? 7 : 4; wy = f ? 5 : 2;
    step(0, 0, 0, 1, 0); step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    for (int y = 0; y < 140; y++) begin
      step(0, 0, 1, 0, 0); step(0, 0, 1, 0, 0);
      step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
      for (int x = 0; x < 40; x++) begin
        b = int'(f) * 2 + (x & 1);
        inw = (x >= wx) && (x < wx + 16) && (y >= wy) && (y < wy + 128);
        if (inw) begin
          p = base[b] + lvl + (y & 1);
          sum[x & 1] += p;
        end else p = (x * 53 + y * 29 + lvl * 7 + int'(f) * 11) % 1024;
        off = en ? appl[b] : fixv[int'(f) * 4 + (y & 1) * 2 + (x & 1)];
        d = p - off;
        if (d < 0) d = 0;
        if (d > 1023) d = 1023;
        step(1, 10'(p), 0, 0, 10'(d));
      end
      step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    end
    step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    meas[int'(f) * 2]     = sum[0] >> 10;
    meas[int'(f) * 2 + 1] = sum[1] >> 10;
    if (en) check(bad_pix == 0, "R5,R6 clamp pixels", first_act, first_exp);
    else    check(bad_pix == 0, "R7 fixed offset pixels", first_act, first_exp);
    check(bad_lat == 0, "R8 latency/hold", bad_lat, 0);
    for (int i = 0; i < 4; i++)
      check(int'(black_lvl[i*10 +: 10]) == meas[i],
            en ? "R2,R3,R4 black level" : "R9 black level in bypass",
            int'(black_lvl[i*10 +: 10]), meas[i]);
  endtask

  task automatic do_reset();
    rst = 1'b1; pix_vld = 0; hs = 0; vs = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    prev_v = 0; prev_e = '0; last_e = '0;
    for (int i = 0; i < 4; i++) meas[i] = 0;
  endtask

  initial begin
    for (int k = 0; k < 8; k++) fix_ofs[k*11 +: 11] = 11'(fixv[k]);
    do_reset();
    @(negedge clk);
    check(out_vld == 1'b0, "R1 reset out_vld", int'(out_vld), 0);
    check(out_pix == '0, "R1 reset out_pix", int'(out_pix), 0);
    check(black_lvl == '0, "R1 reset black_lvl", 0, 0);
    for (int i = 0; i < NVEC; i++)
      run_frame(VEC[i][9], VEC[i][8], int'(VEC[i][7:0]));
    // directed: reset after measurements must discard stored levels (R1)
    do_reset();
    @(negedge clk);
    check(black_lvl == '0, "R1 reset clears levels", 0, 0);
    check(out_pix == '0, "R1 reset clears output", int'(out_pix), 0);
    // first clamp frame after reset subtracts zero levels (R1, R5)
    run_frame(1'b1, 1'b0, 3);
    // bypass on odd field after clamp frames (R7, R9)
    run_frame(1'b0, 1'b1, 40);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule